// File: doc/BRIEF.md
# Accumulator ALU with Carry and Auxiliary Carry

This block is the accumulator datapath of a small 8-bit controller. Each cycle in which `op_valid` is high it takes an 8-bit opcode and an already-resolved 8-bit operand. It updates the accumulator, the carry flag and the auxiliary (half) carry flag from the opcode alone. The caller fetches the instruction and supplies the operand value, whether it came from an immediate byte, a working register or RAM. The block does no addressing and no memory access.

The block decodes a fixed opcode map. It covers:

- binary add, with and without the carry in;
- the three bitwise logic operations;
- accumulator clear, complement, increment and decrement;
- clear and complement of the carry flag;
- rotates of the accumulator, both plain and through the carry;
- a swap of the two nibbles;
- a decimal adjust that uses the auxiliary carry to repair the result of a packed BCD add.

A strobed opcode outside this set changes no state and raises `unhandled` for one cycle, so that a neighbouring unit can take it.

Every update lands at the clock edge that samples the strobe. The new values are visible at the outputs in the following cycle.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first strobe, `acc` is 0x00 and `carry`, `aux_carry` and `unhandled` are 0.
- R2: Opcodes 0x03, 0x60–0x61 and 0x68–0x6F add the operand to `acc`. Opcodes 0x13, 0x70–0x71 and 0x78–0x7F add the operand plus `carry`. In both cases the result is taken modulo 256, `carry` becomes the carry out of bit 7 and `aux_carry` becomes the carry out of bit 3.
- R3: The bitwise logic opcodes are:
  - AND: 0x53, 0x50–0x51 and 0x58–0x5F.
  - OR: 0x43, 0x40–0x41 and 0x48–0x4F.
  - XOR: 0xD3, 0xD0–0xD1 and 0xD8–0xDF.

  Each combines `acc` with the operand bitwise and leaves both flags unchanged.
- R4: 0x27 sets `acc` to 0, 0x37 inverts every bit, 0x17 adds 1 and 0x07 subtracts 1 (both modulo 256). None of these changes a flag.
- R5: 0x97 clears `carry` and 0xA7 inverts it. `acc` and `aux_carry` are unchanged.
- R6: 0xE7 rotates `acc` left by one bit (bit 7 to bit 0) and 0x77 rotates it right by one bit (bit 0 to bit 7). Both flags are unchanged.
- R7: 0xF7 rotates the 9-bit value {carry, acc} left, so `carry` takes bit 7 and bit 0 takes the old carry. 0x67 rotates it right, so `carry` takes bit 0 and bit 7 takes the old carry. `aux_carry` is unchanged.
- R8: 0x47 exchanges bits 7:4 and bits 3:0 of `acc`. The flags are unchanged.
- R9: 0x57 applies decimal adjust in two steps:
  - First, if `acc[3:0]` > 9 or `aux_carry` = 1, add 0x06 modulo 256.
  - Then, if the high nibble of that value is > 9 or `carry` = 1, add 0x60 and set `carry` when this addition overflows. Otherwise `carry` keeps its value.

  `aux_carry` is unchanged.
- R10: A strobed opcode outside R2–R9 leaves `acc`, `carry` and `aux_carry` unchanged. `unhandled` is 1 in the cycle after that strobe and 0 after every other cycle.
- R11: With `op_valid` low, `opcode` and `operand` are ignored and all three state values hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Execute `opcode` in this cycle |
| opcode | input | 8 | Instruction byte |
| operand | input | 8 | Resolved source operand |
| acc | output | 8 | Accumulator |
| carry | output | 1 | Carry flag |
| aux_carry | output | 1 | Auxiliary carry out of bit 3 |
| unhandled | output | 1 | Previous strobed opcode was not executed |

## Verification
The accumulator and both flags are outputs, so a wrong internal state shows at the ports one cycle after the strobe that caused it. A mis-decoded opcode shows in the same way, and the error stays visible until the next strobe.

An error in the auxiliary carry is different. It is invisible at first and surfaces only at the next decimal adjust. For that reason the bench places each decimal adjust after a fresh add and sweeps all 1024 combinations of accumulator and flags. Every opcode is also swept from several starting states, so that a stray write to a flag is caught on the very next cycle.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int NIB_W   = 4;
  localparam int DATA_W  = 2 * NIB_W;
  localparam int BCD_MAX = 9;
  localparam int LO_FIX  = 6;

  typedef enum logic [4:0] {
    CLS_NONE, CLS_ADD, CLS_ADDC, CLS_AND, CLS_OR, CLS_XOR,
    CLS_CLRA, CLS_CPLA, CLS_INCA, CLS_DECA, CLS_CLRC, CLS_CPLC,
    CLS_RL, CLS_RR, CLS_RLC, CLS_RRC, CLS_SWAP, CLS_DAA
  } op_cls_e;

  typedef struct packed {
    logic              c;
    logic              ac;
    logic [DATA_W-1:0] sum;
  } add_res_t;

  typedef struct packed {
    logic              lo_fix;
    logic              hi_fix;
    logic              c;
    logic [DATA_W-1:0] val;
  } daa_res_t;

  // Nibble-wise add so that the half carry is a real intermediate.
  function automatic add_res_t add_bytes(input logic [DATA_W-1:0] a,
                                         input logic [DATA_W-1:0] b,
                                         input logic cin);
    logic [NIB_W:0] lo;
    logic [NIB_W:0] hi;
    add_res_t r;
    lo = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
    hi = {1'b0, a[DATA_W-1:NIB_W]} + {1'b0, b[DATA_W-1:NIB_W]}
       + {{NIB_W{1'b0}}, lo[NIB_W]};
    r.sum = {hi[NIB_W-1:0], lo[NIB_W-1:0]};
    r.c   = hi[NIB_W];
    r.ac  = lo[NIB_W];
    return r;
  endfunction

  // Two-step packed BCD correction.
  function automatic daa_res_t bcd_adjust(input logic [DATA_W-1:0] a,
                                          input logic c,
                                          input logic ac);
    logic [DATA_W-1:0] t;
    logic [DATA_W:0]   u;
    daa_res_t r;
    r.lo_fix = (a[NIB_W-1:0] > NIB_W'(BCD_MAX)) || ac;
    t        = r.lo_fix ? a + DATA_W'(LO_FIX) : a;
    r.hi_fix = (t[DATA_W-1:NIB_W] > NIB_W'(BCD_MAX)) || c;
    u        = r.hi_fix ? {1'b0, t} + (DATA_W+1)'(LO_FIX << NIB_W) : {1'b0, t};
    r.val    = u[DATA_W-1:0];
    r.c      = c | u[DATA_W];
    return r;
  endfunction

endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
  import acc_alu_pkg::*;
(
  input  logic [DATA_W-1:0] opcode,
  output op_cls_e           op_cls,
  output logic              op_known
);

  always_comb begin
    casez (opcode)
      8'h03, 8'b0110_000?, 8'b0110_1???: op_cls = CLS_ADD;
      8'h13, 8'b0111_000?, 8'b0111_1???: op_cls = CLS_ADDC;
      8'h53, 8'b0101_000?, 8'b0101_1???: op_cls = CLS_AND;
      8'h43, 8'b0100_000?, 8'b0100_1???: op_cls = CLS_OR;
      8'hD3, 8'b1101_000?, 8'b1101_1???: op_cls = CLS_XOR;
      8'h27:                             op_cls = CLS_CLRA;
      8'h37:                             op_cls = CLS_CPLA;
      8'h17:                             op_cls = CLS_INCA;
      8'h07:                             op_cls = CLS_DECA;
      8'h97:                             op_cls = CLS_CLRC;
      8'hA7:                             op_cls = CLS_CPLC;
      8'hE7:                             op_cls = CLS_RL;
      8'h77:                             op_cls = CLS_RR;
      8'hF7:                             op_cls = CLS_RLC;
      8'h67:                             op_cls = CLS_RRC;
      8'h47:                             op_cls = CLS_SWAP;
      8'h57:                             op_cls = CLS_DAA;
      default:                           op_cls = CLS_NONE;
    endcase
  end

  assign op_known = (op_cls != CLS_NONE);

endmodule

// File: rtl/acc_alu_exec.sv
module acc_alu_exec
  import acc_alu_pkg::*;
(
  input  op_cls_e           op_cls,
  input  logic [DATA_W-1:0] acc_q,
  input  logic              c_q,
  input  logic              ac_q,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] acc_d,
  output logic              c_d,
  output logic              ac_d
);

  logic [DATA_W-1:0] rl_vec;
  logic [DATA_W-1:0] rr_vec;
  logic              add_cin;
  add_res_t          add_r;
  daa_res_t          daa_r;

  for (genvar i = 0; i < DATA_W; i++) begin : g_rot
    assign rl_vec[i] = acc_q[(i + DATA_W - 1) % DATA_W];
    assign rr_vec[i] = acc_q[(i + 1) % DATA_W];
  end

  assign add_cin = (op_cls == CLS_ADDC) ? c_q : 1'b0;
  assign add_r   = add_bytes(acc_q, operand, add_cin);
  assign daa_r   = bcd_adjust(acc_q, c_q, ac_q);

  always_comb begin
    acc_d = acc_q;
    c_d   = c_q;
    ac_d  = ac_q;
    unique case (op_cls)
      CLS_ADD, CLS_ADDC: begin
        acc_d = add_r.sum;
        c_d   = add_r.c;
        ac_d  = add_r.ac;
      end
      CLS_AND:  acc_d = acc_q & operand;
      CLS_OR:   acc_d = acc_q | operand;
      CLS_XOR:  acc_d = acc_q ^ operand;
      CLS_CLRA: acc_d = '0;
      CLS_CPLA: acc_d = ~acc_q;
      CLS_INCA: acc_d = acc_q + DATA_W'(1);
      CLS_DECA: acc_d = acc_q - DATA_W'(1);
      CLS_CLRC: c_d   = 1'b0;
      CLS_CPLC: c_d   = ~c_q;
      CLS_RL:   acc_d = rl_vec;
      CLS_RR:   acc_d = rr_vec;
      CLS_RLC: begin
        acc_d = {rl_vec[DATA_W-1:1], c_q};
        c_d   = acc_q[DATA_W-1];
      end
      CLS_RRC: begin
        acc_d = {c_q, rr_vec[DATA_W-2:0]};
        c_d   = acc_q[0];
      end
      CLS_SWAP: acc_d = {acc_q[NIB_W-1:0], acc_q[DATA_W-1:NIB_W]};
      CLS_DAA: begin
        acc_d = daa_r.val;
        c_d   = daa_r.c;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [DATA_W-1:0] opcode,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] acc,
  output logic              carry,
  output logic              aux_carry,
  output logic              unhandled
);

  op_cls_e           op_cls;
  logic              op_known;
  logic              upd_fire;
  logic              unh_fire;
  logic [DATA_W-1:0] acc_q, acc_d;
  logic              c_q, c_d;
  logic              ac_q, ac_d;
  logic              unh_q;

  acc_alu_decode u_decode (
    .opcode   (opcode),
    .op_cls   (op_cls),
    .op_known (op_known)
  );

  acc_alu_exec u_exec (
    .op_cls  (op_cls),
    .acc_q   (acc_q),
    .c_q     (c_q),
    .ac_q    (ac_q),
    .operand (operand),
    .acc_d   (acc_d),
    .c_d     (c_d),
    .ac_d    (ac_d)
  );

  assign upd_fire = op_valid & op_known;
  assign unh_fire = op_valid & ~op_known;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      c_q   <= 1'b0;
      ac_q  <= 1'b0;
      unh_q <= 1'b0;
    end else begin
      unh_q <= unh_fire;
      if (upd_fire) begin
        acc_q <= acc_d;
        c_q   <= c_d;
        ac_q  <= ac_d;
      end
    end
  end

  assign acc       = acc_q;
  assign carry     = c_q;
  assign aux_carry = ac_q;
  assign unhandled = unh_q;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic [7:0] opcode,
  input logic [7:0] acc,
  input logic       carry,
  input logic       aux_carry,
  input logic       unhandled,
  input logic       op_known
);

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(acc) && $stable(carry) && $stable(aux_carry));

  a_r10_unknown_flags: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !op_known |=> unhandled && $stable(acc) && $stable(carry) && $stable(aux_carry));

  a_r10_flag_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && !op_known) |=> !unhandled);

  a_r4_clear_acc: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && opcode == 8'h27 |=> acc == 8'h00 && $stable(carry) && $stable(aux_carry));

  a_r5_clear_carry: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && opcode == 8'h97 |=> !carry && $stable(acc) && $stable(aux_carry));

  a_r6_rotate_keeps_c: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (opcode == 8'hE7 || opcode == 8'h77) |=> $stable(carry) && $stable(aux_carry));

  a_r8_swap_nibbles: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && opcode == 8'h47 |=> acc == {$past(acc[3:0]), $past(acc[7:4])});

  a_r9_daa_c_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && opcode == 8'h57 && carry |=> carry && $stable(aux_carry));

endmodule

bind acc_alu acc_alu_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .opcode    (opcode),
  .acc       (acc),
  .carry     (carry),
  .aux_carry (aux_carry),
  .unhandled (unhandled),
  .op_known  (op_known)
);

// File: tb/acc_alu_bench.sv
`timescale 1ns/1ps
module acc_alu_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic [7:0] operand = 8'h00;
  logic [7:0] acc;
  logic       carry, aux_carry, unhandled;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  int e_a = 0;
  int e_c = 0;
  int e_ac = 0;
  int e_unh = 0;

  always #10 clk = ~clk;

  acc_alu u_acc_alu (
    .clk (clk), .rst_n (rst_n), .op_valid (op_valid), .opcode (opcode),
    .operand (operand), .acc (acc), .carry (carry), .aux_carry (aux_carry),
    .unhandled (unhandled)
  );

  function automatic bit in_rng(int op, int lo, int hi);
    return op >= lo && op <= hi;
  endfunction

  function automatic string req_tag(int op);
    if (op == 'h03 || op == 'h13 || in_rng(op, 'h60, 'h61) || in_rng(op, 'h68, 'h6F)
        || in_rng(op, 'h70, 'h71) || in_rng(op, 'h78, 'h7F)) return "R2";
    if (op == 'h53 || op == 'h43 || op == 'hD3 || in_rng(op, 'h40, 'h41) || in_rng(op, 'h48, 'h4F)
        || in_rng(op, 'h50, 'h51) || in_rng(op, 'h58, 'h5F) || in_rng(op, 'hD0, 'hD1)
        || in_rng(op, 'hD8, 'hDF)) return "R3";
    if (op == 'h27 || op == 'h37 || op == 'h17 || op == 'h07) return "R4";
    if (op == 'h97 || op == 'hA7) return "R5";
    if (op == 'hE7 || op == 'h77) return "R6";
    if (op == 'hF7 || op == 'h67) return "R7";
    if (op == 'h47) return "R8";
    if (op == 'h57) return "R9";
    return "R10";
  endfunction

  // Reference model written from the requirement text.
  task automatic model(input int op, input int v);
    string t;
    int s;
    int cin;
    t = req_tag(op);
    e_unh = 0;
    if (t == "R2") begin
      cin  = (op == 'h13 || op >= 'h70) ? e_c : 0;
      s    = e_a + v + cin;
      e_ac = ((e_a % 16) + (v % 16) + cin) >= 16;
      e_c  = s >= 256;
      e_a  = s % 256;
    end else if (t == "R3") begin
      if (op == 'h53 || (op >> 4) == 5) e_a = e_a & v;
      else if (op == 'h43 || (op >> 4) == 4) e_a = e_a | v;
      else e_a = e_a ^ v;
    end else if (op == 'h27) e_a = 0;
    else if (op == 'h37) e_a = 255 - e_a;
    else if (op == 'h17) e_a = (e_a + 1) % 256;
    else if (op == 'h07) e_a = (e_a + 255) % 256;
    else if (op == 'h97) e_c = 0;
    else if (op == 'hA7) e_c = 1 - e_c;
    else if (op == 'hE7) e_a = (e_a * 2) % 256 + e_a / 128;
    else if (op == 'h77) e_a = e_a / 2 + (e_a % 2) * 128;
    else if (op == 'hF7) begin s = e_a; e_a = (s * 2) % 256 + e_c; e_c = s / 128; end
    else if (op == 'h67) begin s = e_a; e_a = s / 2 + e_c * 128; e_c = s % 2; end
    else if (op == 'h47) e_a = (e_a % 16) * 16 + e_a / 16;
    else if (op == 'h57) begin
      s = e_a;
      if (s % 16 > 9 || e_ac == 1) s = (s + 6) % 256;
      if (s / 16 > 9 || e_c == 1) begin
        s = s + 96;
        if (s >= 256) begin e_c = 1; s = s - 256; end
      end
      e_a = s;
    end else e_unh = 1;
  endtask

  task automatic check(input string tag, input int op);
    checks++;
    if (int'(acc) != e_a || int'(carry) != e_c || int'(aux_carry) != e_ac
        || int'(unhandled) != e_unh) begin
      errors++;
      $display("FAIL %s op=%02h acc=%02h/%02h c=%0d/%0d ac=%0d/%0d unh=%0d/%0d",
               tag, op, acc, e_a, carry, e_c, aux_carry, e_ac, unhandled, e_unh);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic do_op(input int op, input int v);
    opcode   = 8'(op);
    operand  = 8'(v);
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    model(op, v);
    check(req_tag(op), op);
  endtask

  task automatic idle(input int op, input int v);
    opcode   = 8'(op);
    operand  = 8'(v);
    op_valid = 1'b0;
    @(negedge clk);
    e_unh = 0;
    check("R11", op);
  endtask

  task automatic set_state(input int a, input int c, input int ac);
    do_op('h27, 0);
    do_op('h97, 0);
    if (ac != 0) begin do_op('h03, 8); do_op('h03, 8); end
    else do_op('h03, 0);
    do_op('h53, 0);
    do_op('h43, a);
    do_op('h97, 0);
    if (c != 0) do_op('hA7, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 0);                 // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 0);                 // R1 after release
    idle('h27, 'h55);               // R11 before any strobe

    // Every opcode from four starting states with three operands.
    for (int op = 0; op < 256; op++) begin
      for (int si = 0; si < 4; si++) begin
        for (int vi = 0; vi < 3; vi++) begin
          case (si)
            0: set_state('h00, 0, 0);
            1: set_state('h99, 1, 0);
            2: set_state('hFF, 0, 1);
            default: set_state('h3C, 1, 1);
          endcase
          do_op(op, (vi == 0) ? 'h00 : (vi == 1) ? 'h7F : 'hA5);
        end
      end
    end

    // R9: decimal adjust over every accumulator and flag combination.
    for (int a = 0; a < 256; a++)
      for (int f = 0; f < 4; f++) begin
        set_state(a, f % 2, f / 2);
        do_op('h57, 0);
      end

    // R2: sweep of add and add-with-carry sums.
    for (int a = 0; a < 256; a += 7)
      for (int v = 0; v < 256; v += 11)
        for (int f = 0; f < 2; f++) begin
          set_state(a, f, 0);
          do_op((f == 0) ? 'h03 : 'h7B, v);
          do_op('h13, 255 - v);
        end

    // R10 flag falls after one idle cycle; R11 held state ignores opcodes.
    set_state('hA5, 1, 1);
    do_op('h00, 'h12);
    idle('h27, 'h00);
    idle('h03, 'hFF);
    do_op('hC7, 'h34);
    do_op('h17, 0);                 // R10 flag drops after a handled strobe

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule